// File: doc/BRIEF.md
# DRAM Compressed Test-Mode Logic

This block is a synchronous behavioural model of the test-mode logic of a four-bit-wide dynamic memory. Each data bit is stored in four sub-blocks. The two lowest column address bits choose the sub-block in normal operation. The model samples the row strobe, column strobe, write enable, output enable, the multiplexed address bus and the data pins on every rising clock edge. From these samples it rebuilds the row cycles, column accesses and refresh cycles that a memory controller would issue.

A column strobe and write enable both held low ahead of the row strobe falling form a write-strobe-before-row cycle. When the row address carries a fixed key of all ones on its low `KEY_W` bits, this cycle switches the model into a compressed test mode. In test mode a write copies each data pin into all four sub-blocks at once. A read returns, per data pin, a 1 when the four stored copies agree and a 0 when they disagree. A tester can then cover the array in a quarter of the accesses. Any of the three refresh forms ends the test mode:

- a column-before-row refresh with write enable high,
- a row-only refresh,
- a hidden refresh.

Top module: `tmdram_top`

## Requirements
- R1: A row strobe falling edge sampled while the column strobe and write enable are both low, with address bits [KEY_W-1:0] all 1, sets `test_mode` at that edge. Address bits at and above KEY_W are ignored.
- R2: In test mode a write stores `dq_in` into all four column addresses that share column bits [ADDR_W-1:2] in the open row. Column bits [1:0] are ignored.
- R3: In test mode a read captures, for each data bit b, 1 when the four stored copies of bit b in the addressed group are equal and 0 otherwise.
- R4: `test_mode` clears at the row strobe falling edge of a column-before-row cycle with write enable high, including a hidden refresh. It also clears at the row strobe rising edge of a row cycle that saw no column strobe falling edge.
- R5: A write-strobe-before-row cycle without the key acts as a plain refresh and leaves `test_mode` unchanged. A row cycle that contains a column access leaves `test_mode` unchanged.
- R6: In normal mode each column access reads or writes only the cell at the latched row and the full column address. Column bits [1:0] pick the sub-block. Several column accesses may follow within one row cycle.
- R7: A write enable falling edge while a read access is open writes `dq_in` to the latched column at that edge, and `dq_oe` drops at the same edge.
- R8: `dq_oe` is 1 only while a read access is open, the column strobe is low and output enable is low. `dq_out` holds the value captured at the column strobe falling edge, also across a hidden refresh. The column strobe and output enable are judged on their last samples.
- R9: After reset `test_mode` and `dq_oe` are 0 and every array cell reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the data pins |
| dq_out | output | DQ_W | Read data or per-bit compare result |
| dq_oe | output | 1 | Data pins driven when 1 |
| test_mode | output | 1 | Compressed test mode active |

## Verification
A hidden refresh issued during a test-mode read puts two functions into one clock edge. The mode exit takes effect while the compare result captured under the old mode is still on the pins. The bench provokes this by opening a test-mode read, then raising and dropping the row strobe with the column strobe held low. It then checks that `test_mode` is 0 while `dq_oe` stays 1 and `dq_out` still equals the compare value computed from the bench's own array model. A read-modify-write puts a second pair into one edge: a late write lands while the read output is open. The bench checks that the write data reaches the cell and the pins release at the same edge.

// File: rtl/tmdram_pkg.sv
// Shared types and constants of the compressed test-mode memory model.
// Assumes each data bit is split over four sub-blocks selected by two column bits.
package tmdram_pkg;
    localparam int SUB_W = 2;
    localparam int SUBS  = 1 << SUB_W;

    typedef enum logic [1:0] {
        CY_IDLE = 2'd0,
        CY_ROW  = 2'd1,
        CY_REFR = 2'd2
    } cyc_state_e;
endpackage

// File: rtl/tmdram_cycle_dec.sv
// Cycle decoder: turns sampled strobe levels into row, column, write and
// refresh events. Assumes strobes are already synchronous to clk; edges are
// found by comparing each sample with the previous one.
module tmdram_cycle_dec
    import tmdram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              ev_cbr,
    output logic              cbr_we_n,
    output logic              ev_ror,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_col,
    output logic              rd_cap,
    output logic              rd_open,
    output logic [ADDR_W-1:0] row_r
);
    cyc_state_e        st;
    logic              ras_q, cas_q, we_q, had_col;
    logic [ADDR_W-1:0] col_r;
    logic              ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic              row_open, col_fall, early_wr, late_wr;

    // Edge detection against the previous samples.
    always_comb begin
        ras_fall = ras_q & ~ras_n;
        ras_rise = ~ras_q & ras_n;
        cas_fall = cas_q & ~cas_n;
        cas_rise = ~cas_q & cas_n;
        we_fall  = we_q & ~we_n;
    end

    // Event decode from state and edges.
    always_comb begin
        ev_cbr   = (st == CY_IDLE) & ras_fall & ~cas_n;
        cbr_we_n = we_n;
        row_open = (st == CY_IDLE) & ras_fall & cas_n;
        col_fall = (st == CY_ROW) & cas_fall;
        early_wr = col_fall & ~we_n;
        rd_cap   = col_fall & we_n;
        late_wr  = (st == CY_ROW) & rd_open & ~cas_n & we_fall;
        ev_ror   = (st == CY_ROW) & ras_rise & ~had_col;
        wr_en    = early_wr | late_wr;
        wr_col   = early_wr ? addr : col_r;
    end

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    // Cycle state, row/column latches and column-seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= CY_IDLE;
            row_r   <= '0;
            col_r   <= '0;
            had_col <= 1'b0;
        end else begin
            case (st)
                CY_IDLE: begin
                    if (ev_cbr) begin
                        st <= CY_REFR;
                    end else if (row_open) begin
                        st      <= CY_ROW;
                        row_r   <= addr;
                        had_col <= 1'b0;
                    end
                end
                CY_ROW: begin
                    if (col_fall) begin
                        col_r   <= addr;
                        had_col <= 1'b1;
                    end
                    if (ras_rise) st <= CY_IDLE;
                end
                CY_REFR: begin
                    if (ras_rise) st <= CY_IDLE;
                end
                default: st <= CY_IDLE;
            endcase
        end
    end

    // Read access window: opens on a read column edge, closes on strobe rise or late write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_open <= 1'b0;
        else if (rd_cap)              rd_open <= 1'b1;
        else if (cas_rise || late_wr) rd_open <= 1'b0;
    end

    AST_OPEN_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_open |-> !cas_q);  // R8
    AST_LATE_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        late_wr |=> !rd_open);  // R7
endmodule

// File: rtl/tmdram_mode_ctl.sv
// Test-mode flag: set by a keyed write-strobe-before-row cycle, cleared by
// any refresh form. Assumes the decoder pulses ev_cbr for one clock per
// column-before-row cycle and ev_ror at the close of a column-free row cycle.
module tmdram_mode_ctl #(
    parameter int KEY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_cbr,
    input  logic             cbr_we_n,
    input  logic             ev_ror,
    input  logic [KEY_W-1:0] key_bits,
    output logic             test_mode
);
    logic key_ok, enter, leave;

    // Entry and exit decode.
    always_comb begin
        key_ok = &key_bits;
        enter  = ev_cbr & ~cbr_we_n & key_ok;
        leave  = (ev_cbr & cbr_we_n) | ev_ror;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)     test_mode <= 1'b0;
        else if (enter) test_mode <= 1'b1;
        else if (leave) test_mode <= 1'b0;
    end

    AST_KEY_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cbr && !cbr_we_n && (&key_bits)) |=> test_mode);  // R1
    AST_KEYLESS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cbr && !cbr_we_n && !(&key_bits)) |=> $stable(test_mode));  // R5
    AST_CBR_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cbr && cbr_we_n) |=> !test_mode);  // R4
    AST_ROR_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ror |=> !test_mode);  // R4
endmodule

// File: rtl/tmdram_array.sv
// Storage array with four sub-blocks per data bit. Normal access picks one
// sub-block with column bits [1:0]; test write replicates into all four;
// test read returns a per-bit agreement flag. Read is combinational.
module tmdram_array
    import tmdram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_test,
    input  logic [ADDR_W-1:0] wr_row,
    input  logic [ADDR_W-1:0] wr_col,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_row,
    input  logic [ADDR_W-1:0] rd_col,
    input  logic              rd_test,
    output logic [DQ_W-1:0]   rd_data
);
    localparam int ROWS = 1 << ADDR_W;
    localparam int COLS = 1 << ADDR_W;
    localparam int CU_W = ADDR_W - SUB_W;

    logic [DQ_W-1:0]  mem [ROWS][COLS];
    logic [CU_W-1:0]  rd_cu;
    logic [DQ_W-1:0]  agree;
    logic [SUBS-1:0]  grp [DQ_W];

    assign rd_cu = rd_col[ADDR_W-1:SUB_W];

    // Per-bit gathering of the four copies and their agreement flag.
    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
        for (genvar s = 0; s < SUBS; s++) begin : g_sub
            localparam logic [SUB_W-1:0] SIDX = SUB_W'(s);
            assign grp[b][s] = mem[rd_row][{rd_cu, SIDX}][b];
        end
        assign agree[b] = (&grp[b]) | ~(|grp[b]);
    end

    // Read mux: compare result in test mode, single cell otherwise.
    always_comb begin
        rd_data = rd_test ? agree : mem[rd_row][rd_col];
    end

    // Cell writes: one sub-block normally, all four in test mode; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    mem[r][c] <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < SUBS; s++)
                if (wr_test || (wr_col[SUB_W-1:0] == SUB_W'(s)))
                    mem[wr_row][{wr_col[ADDR_W-1:SUB_W], SUB_W'(s)}] <= wr_data;
        end
    end

    // Checker registers remembering the last test write for the replication check.
    logic              chk_pend;
    logic [ADDR_W-1:0] chk_row;
    logic [CU_W-1:0]   chk_cu;
    logic [DQ_W-1:0]   chk_d;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_pend <= 1'b0;
            chk_row  <= '0;
            chk_cu   <= '0;
            chk_d    <= '0;
        end else begin
            chk_pend <= wr_en & wr_test;
            chk_row  <= wr_row;
            chk_cu   <= wr_col[ADDR_W-1:SUB_W];
            chk_d    <= wr_data;
        end
    end

    AST_TEST_WRITE_FILLS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        chk_pend |-> (mem[chk_row][{chk_cu, 2'd0}] == chk_d) && (mem[chk_row][{chk_cu, 2'd1}] == chk_d)
                  && (mem[chk_row][{chk_cu, 2'd2}] == chk_d) && (mem[chk_row][{chk_cu, 2'd3}] == chk_d));  // R2
endmodule

// File: rtl/tmdram_top.sv
// Top of the compressed test-mode memory model. Samples the strobes each
// clock, decodes cycles, keeps the mode flag, and captures read data at the
// column strobe falling edge. Assumes KEY_W <= ADDR_W and ADDR_W > 2.
module tmdram_top #(
    parameter int ADDR_W = 4,
    parameter int DQ_W   = 4,
    parameter int KEY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              test_mode
);
    logic              ev_cbr, cbr_we_n, ev_ror, wr_en, rd_cap, rd_open;
    logic [ADDR_W-1:0] wr_col, row_r;
    logic [DQ_W-1:0]   rd_data, dout_r;
    logic              oe_q;

    tmdram_cycle_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ev_cbr(ev_cbr), .cbr_we_n(cbr_we_n), .ev_ror(ev_ror),
        .wr_en(wr_en), .wr_col(wr_col), .rd_cap(rd_cap), .rd_open(rd_open),
        .row_r(row_r)
    );

    tmdram_mode_ctl #(.KEY_W(KEY_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .ev_cbr(ev_cbr), .cbr_we_n(cbr_we_n),
        .ev_ror(ev_ror), .key_bits(addr[KEY_W-1:0]), .test_mode(test_mode)
    );

    tmdram_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_test(test_mode),
        .wr_row(row_r), .wr_col(wr_col), .wr_data(dq_in),
        .rd_row(row_r), .rd_col(addr), .rd_test(test_mode), .rd_data(rd_data)
    );

    // Output-enable sample and read data capture at the column edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b1;
            dout_r <= '0;
        end else begin
            oe_q <= oe_n;
            if (rd_cap) dout_r <= rd_data;
        end
    end

    // Pin drive: enabled only during an open read with output enable low.
    always_comb begin
        dq_oe  = rd_open & ~oe_q;
        dq_out = dout_r;
    end

    AST_HOLD_ACROSS_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe) && !$past(rd_cap)) |-> $stable(dq_out));  // R8
endmodule

// File: tb/tmdram_top_bench.sv
// Bench: exhaustive sweeps over a 16x16x4 array with an arithmetic reference model.
module tmdram_top_bench;
    localparam int AW = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, test_mode;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;
    logic [3:0] m [16][16];

    tmdram_top #(.ADDR_W(AW), .DQ_W(DW), .KEY_W(3)) u_tmdram_top (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .test_mode(test_mode)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog expired act %0d exp <150000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic drv(input logic r, input logic c, input logic w, input logic o,
                       input int a, input int d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        addr = 4'(a); dq_in = 4'(d);
    endtask

    task automatic look;
        @(negedge clk);
    endtask

    function automatic logic [3:0] cmpv(input int r, input int cu);
        logic [3:0] v;
        for (int b = 0; b < 4; b++) begin
            v[b] = (m[r][cu*4][b] == m[r][cu*4+1][b]) && (m[r][cu*4][b] == m[r][cu*4+2][b])
                && (m[r][cu*4][b] == m[r][cu*4+3][b]);
        end
        return v;
    endfunction

    task automatic open_row(input int r);
        drv(1, 1, 1, 1, r, 0);
        drv(0, 1, 1, 1, r, 0);
    endtask

    task automatic close_row;
        drv(0, 1, 1, 1, 0, 0);
        drv(1, 1, 1, 1, 0, 0);
    endtask

    task automatic col_write(input int c, input int d);
        drv(0, 0, 0, 1, c, d);
        drv(0, 1, 1, 1, c, d);
    endtask

    task automatic col_read(input int c, output logic [3:0] v, output logic oe);
        drv(0, 0, 1, 0, c, 0);
        look;
        v = dq_out;
        oe = dq_oe;
        drv(0, 1, 1, 1, c, 0);
    endtask

    task automatic cbr_cycle(input logic w, input int a);
        drv(1, 0, w, 1, 0, 0);
        drv(0, 0, w, 1, a, 0);
        drv(0, 1, 1, 1, 0, 0);
        drv(1, 1, 1, 1, 0, 0);
        look;
    endtask

    task automatic ror_cycle(input int r);
        drv(1, 1, 1, 1, r, 0);
        drv(0, 1, 1, 1, r, 0);
        drv(1, 1, 1, 1, r, 0);
        look;
    endtask

    // Read every cell in normal mode against the model.
    task automatic sweep_normal(input string tag);
        logic [3:0] v;
        logic oe;
        for (int r = 0; r < 16; r++) begin
            open_row(r);
            for (int c = 0; c < 16; c++) begin
                col_read(c, v, oe);
                chk({tag, " data"}, v, m[r][c]);
                chk({tag, " R8 oe"}, oe, 1);
            end
            close_row;
        end
    endtask

    // Read every group in test mode against the model compare.
    task automatic sweep_test(input string tag);
        logic [3:0] v;
        logic oe;
        for (int r = 0; r < 16; r++) begin
            open_row(r);
            for (int cu = 0; cu < 4; cu++) begin
                col_read(cu*4 + ((r + cu) & 3), v, oe);
                chk(tag, v, cmpv(r, cu));
            end
            close_row;
        end
    endtask

    initial begin
        logic [3:0] v, held;
        logic oe;
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                m[r][c] = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look;
        chk("R9 test_mode after reset", test_mode, 0);
        chk("R9 dq_oe after reset", dq_oe, 0);
        sweep_normal("R9 cleared array");

        // R6: page-mode normal writes of an arithmetic pattern.
        for (int r = 0; r < 16; r++) begin
            open_row(r);
            for (int c = 0; c < 16; c++) begin
                col_write(c, (r*5 + c*3 + 1) & 15);
                m[r][c] = 4'((r*5 + c*3 + 1) & 15);
            end
            close_row;
        end
        sweep_normal("R6 normal");

        // R8: output enable high keeps pins released during a read.
        open_row(3);
        drv(0, 0, 1, 1, 7, 0);
        look;
        chk("R8 oe_n high", dq_oe, 0);
        drv(0, 0, 1, 0, 7, 0);
        look;
        chk("R8 oe_n low", dq_oe, 1);
        chk("R8 data", dq_out, m[3][7]);
        close_row;
        look;
        chk("R8 cas high", dq_oe, 0);

        // R5: keyless write-strobe-before-row cycle.
        cbr_cycle(0, 4'b1011);
        chk("R5 keyless no entry", test_mode, 0);
        // R1: keyed entry, bit 3 ignored.
        cbr_cycle(0, 4'b0111);
        chk("R1 keyed entry", test_mode, 1);
        sweep_test("R3 compare of pattern");
        chk("R5 reads keep mode", test_mode, 1);
        cbr_cycle(0, 4'b0110);
        chk("R5 keyless in test mode", test_mode, 1);
        cbr_cycle(0, 4'b1111);
        chk("R1 re-entry holds", test_mode, 1);

        // R2: test-mode writes replicate into the group.
        for (int r = 0; r < 16; r++) begin
            open_row(r);
            for (int cu = 0; cu < 4; cu++) begin
                col_write(cu*4 + (r & 3), (r*3 + cu*5 + 2) & 15);
                for (int s = 0; s < 4; s++) m[r][cu*4+s] = 4'((r*3 + cu*5 + 2) & 15);
            end
            close_row;
        end
        sweep_test("R2 R3 replicated compare");
        ror_cycle(9);
        chk("R4 row-only exit", test_mode, 0);
        sweep_normal("R2 replicated cells");

        // R3: one disagreeing cell.
        open_row(2);
        col_write(5, m[2][5] ^ 4'b0101);
        m[2][5] = m[2][5] ^ 4'b0101;
        close_row;
        cbr_cycle(0, 4'b0111);
        chk("R1 entry again", test_mode, 1);
        open_row(2);
        col_read(6, v, oe);
        chk("R3 mismatch bits", v, cmpv(2, 1));
        chk("R3 expected pattern", v, 4'b1010);
        close_row;

        // R4/R8: hidden refresh during a test-mode read.
        open_row(2);
        drv(0, 0, 1, 0, 4, 0);
        look;
        held = dq_out;
        chk("R3 read before hidden", held, cmpv(2, 1));
        drv(1, 0, 1, 0, 4, 0);
        drv(0, 0, 1, 0, 4, 0);
        look;
        chk("R4 hidden refresh exit", test_mode, 0);
        chk("R8 pins held on", dq_oe, 1);
        chk("R8 data held", dq_out, held);
        drv(0, 1, 1, 1, 0, 0);
        drv(1, 1, 1, 1, 0, 0);
        look;
        chk("R8 released", dq_oe, 0);

        // R4: plain column-before-row exit.
        cbr_cycle(0, 4'b0111);
        chk("R1 entry for cbr exit", test_mode, 1);
        cbr_cycle(1, 4'b0111);
        chk("R4 cbr exit", test_mode, 0);

        // R7: read-modify-write with late write enable.
        open_row(11);
        drv(0, 0, 1, 0, 13, 0);
        look;
        chk("R7 read opens", dq_oe, 1);
        chk("R7 read data", dq_out, m[11][13]);
        drv(0, 0, 0, 0, 13, 4'hC ^ m[11][13]);
        look;
        chk("R7 pins released", dq_oe, 0);
        m[11][13] = 4'hC ^ m[11][13];
        close_row;
        open_row(11);
        col_read(13, v, oe);
        chk("R7 late write stored", v, m[11][13]);
        col_read(12, v, oe);
        chk("R6 neighbour untouched", v, m[11][12]);
        close_row;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule